// File: doc/BRIEF.md
# Alert Interrupt Latch with Alert-Response Arbitration

This block holds the shared, active-low alert line of a temperature-monitor slave on a two-wire management bus. Threshold comparators feed it one level signal per alarm condition. When any of them rises while the configuration mask bit is low, an interrupt latch is set and the alert line is pulled low. The line stays low until the host services it. A cleared status flag does not release it.

The host services the alert by reading the bus-wide alert-response address. A byte-level slave front end tells the block when such a read starts and gives it one strobe per data bit, with the value it sampled on SDA. If the latch is set, the block sends a response frame: its own 7-bit address, most significant bit first, followed by a fixed 1.

Several slaves may answer the same read. They arbitrate bit by bit on the wired-AND data line, so the lowest address wins. A device that drives a 1 but samples a 0 has lost. It releases SDA for the rest of the transfer and keeps its alert pending. Only a complete frame sent without loss clears the latch.

Top module: `alert_responder`

## Requirements
- R1: While reset is held, `alertN` is 1 and `sdaDriveLow` is 0.
- R2: A 0-to-1 transition on any bit of `alarmIn` while `maskAll` is 0 sets the latch, and `alertN` is 0 after the clock edge that samples it.
- R3: A level that is already high at reset release, or that stays high, produces no set. Only a new rising transition counts.
- R4: A rising transition that occurs while `maskAll` is 1 is discarded. Clearing the mask later while the alarm stays high does not set the latch. The mask never clears a latch that is already set.
- R5: `alertN` stays 0 for as long as the latch is set, with or without bus traffic, until a winning response completes.
- R6: After `araStart` with the latch set, the block presents the frame {DEV_ADDR[6:0], 1'b1} on SDA, bit 7 first. `sdaDriveLow` is the inverse of the current frame bit. Each `bitStrobe` advances to the next bit.
- R7: `araStart` with the latch clear starts no response, and `sdaDriveLow` stays 0.
- R8: If the current frame bit is 1 and the `bitStrobe` comes with `sdaIn` = 0, the block stops driving for the rest of the transfer, and the latch stays set.
- R9: When the eighth `bitStrobe` of a frame completes without loss, the latch clears and `alertN` is 1 after that edge.
- R10: If a new unmasked rising alarm coincides with the clearing edge, the set wins and `alertN` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alarmIn | input | NUM_ALARMS | Alarm condition levels from the comparators |
| maskAll | input | 1 | Configuration mask bit; 1 blocks new alerts |
| araStart | input | 1 | One-cycle pulse: an alert-response read begins |
| bitStrobe | input | 1 | One-cycle pulse per response bit, at which SDA is sampled |
| sdaIn | input | 1 | Sampled SDA value for the current bit |
| alertN | output | 1 | Alert line enable, active low |
| sdaDriveLow | output | 1 | 1 pulls SDA low for the current response bit |

## Verification
Every result is due one clock edge after the inputs that cause it: the latch state on `alertN`, and the next frame bit or release on `sdaDriveLow`. The driver applies a stimulus on a falling edge. In the same step it queues the outputs expected after the next rising edge. The monitor takes one queued item a quarter period after each rising edge, so each comparison is made exactly one register stage after its stimulus. Arbitration runs against a modelled second responder: the bench computes the wired-AND bus bit from both frames and, from that, the bit at which this device loses.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadFrame;   // load response frame at transfer start
    logic shiftFrame;  // advance to next response bit
    logic clearLatch;  // winning response finished
  } ctlStrobe_t;
endpackage

// File: rtl/alert_resp_dp.sv
module alert_resp_dp
  import alert_resp_pkg::*;
#(
  parameter int NUM_ALARMS = 5,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ALARMS-1:0] alarmIn,
  input  logic                  maskAll,
  input  ctlStrobe_t            strobes,
  output logic                  latchSet,
  output logic                  curBit
);
  localparam int FRAME_W = ADDR_W + 1;

  logic [NUM_ALARMS-1:0] alarmPrev;
  logic [FRAME_W-1:0]    frameReg;
  logic                  setNow;

  // Reset to all ones: a level already high at release is not an edge
  always_ff @(posedge clk) begin
    if (!rstN) alarmPrev <= '1;
    else       alarmPrev <= alarmIn;
  end

  assign setNow = (|(alarmIn & ~alarmPrev)) & ~maskAll;

  // Interrupt latch: a new set takes priority over a clear
  always_ff @(posedge clk) begin
    if (!rstN)                   latchSet <= 1'b0;
    else if (setNow)             latchSet <= 1'b1;
    else if (strobes.clearLatch) latchSet <= 1'b0;
  end

  // Response frame shifter, MSB first, refilled with ones
  always_ff @(posedge clk) begin
    if (!rstN)                   frameReg <= '1;
    else if (strobes.loadFrame)  frameReg <= {DEV_ADDR, 1'b1};
    else if (strobes.shiftFrame) frameReg <= {frameReg[FRAME_W-2:0], 1'b1};
  end

  assign curBit = frameReg[FRAME_W-1];

  // R2
  set_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    setNow |=> latchSet);
  // R9
  clear_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearLatch && !setNow) |=> !latchSet);
  // R5
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchSet && !strobes.clearLatch) |=> latchSet);
  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskAll && !latchSet) |=> !latchSet);
endmodule

// File: rtl/alert_resp_ctrl.sv
module alert_resp_ctrl
  import alert_resp_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       araStart,
  input  logic       bitStrobe,
  input  logic       sdaIn,
  input  logic       latchSet,
  input  logic       curBit,
  output ctlStrobe_t strobes,
  output logic       sending
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t          state;
  logic [CNT_W-1:0] bitCnt;
  logic            lose;
  logic            advance;
  logic            lastBit;

  assign sending = (state == ST_SEND);
  assign lose    = sending & bitStrobe & curBit & ~sdaIn & ~araStart;
  assign advance = sending & bitStrobe & ~lose & ~araStart;
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    strobes            = '0;
    strobes.loadFrame  = araStart & latchSet;
    strobes.shiftFrame = advance;
    strobes.clearLatch = advance & lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (araStart) begin
      state  <= latchSet ? ST_SEND : ST_IDLE;
      bitCnt <= '0;
    end else if (lose) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (advance) begin
      if (lastBit) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R8
  lost_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    lose |=> !sending);
  // R7
  no_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (araStart && !latchSet) |=> !sending);
  // R6
  start_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    (araStart && latchSet) |=> sending);
endmodule

// File: rtl/alert_responder.sv
module alert_responder
  import alert_resp_pkg::*;
#(
  parameter int NUM_ALARMS = 5,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ALARMS-1:0] alarmIn,
  input  logic                  maskAll,
  input  logic                  araStart,
  input  logic                  bitStrobe,
  input  logic                  sdaIn,
  output logic                  alertN,
  output logic                  sdaDriveLow
);
  localparam int FRAME_W = ADDR_W + 1;

  ctlStrobe_t strobes;
  logic       latchSet;
  logic       curBit;
  logic       sending;

  alert_resp_dp #(
    .NUM_ALARMS(NUM_ALARMS),
    .ADDR_W(ADDR_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .alarmIn(alarmIn),
    .maskAll(maskAll),
    .strobes(strobes),
    .latchSet(latchSet),
    .curBit(curBit)
  );

  alert_resp_ctrl #(
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .araStart(araStart),
    .bitStrobe(bitStrobe),
    .sdaIn(sdaIn),
    .latchSet(latchSet),
    .curBit(curBit),
    .strobes(strobes),
    .sending(sending)
  );

  assign alertN      = ~latchSet;
  assign sdaDriveLow = sending & ~curBit;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (alertN && !sdaDriveLow));
endmodule

// File: tb/alert_responder_tb.sv
module alert_responder_tb;
  localparam int PERIOD = 10;
  localparam int NA = 5;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NA-1:0] alarmIn = '0;
  logic          maskAll = 1'b0;
  logic          araStart = 1'b0;
  logic          bitStrobe = 1'b0;
  logic          sdaIn = 1'b1;
  logic          alertN;
  logic          sdaDriveLow;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  bit    expA[$];
  bit    expD[$];
  string tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  alert_responder #(.NUM_ALARMS(NA), .ADDR_W(7), .DEV_ADDR(MY_ADDR)) u_dut (
    .clk(clk), .rstN(rstN), .alarmIn(alarmIn), .maskAll(maskAll),
    .araStart(araStart), .bitStrobe(bitStrobe), .sdaIn(sdaIn),
    .alertN(alertN), .sdaDriveLow(sdaDriveLow)
  );

  // Monitor: results are due one edge after the stimulus
  always @(posedge clk) begin
    #(PERIOD/4);
    if (expA.size() > 0) begin
      bit ea, ed;
      string t;
      ea = expA.pop_front();
      ed = expD.pop_front();
      t  = tagQ.pop_front();
      nTests++;
      if (alertN !== ea || sdaDriveLow !== ed) begin
        nFail++;
        $display("FAIL %s: alertN=%b sdaDriveLow=%b expected alertN=%b sdaDriveLow=%b",
                 t, alertN, sdaDriveLow, ea, ed);
      end
    end
  end

  // Driver: apply one cycle of inputs and queue the expected outputs
  task automatic step(input logic [NA-1:0] al, input logic mk, input logic ara,
                      input logic stb, input logic sda, input bit eA, input bit eD,
                      input string tag);
    @(negedge clk);
    alarmIn = al; maskAll = mk; araStart = ara; bitStrobe = stb; sdaIn = sda;
    expA.push_back(eA);
    expD.push_back(eD);
    tagQ.push_back(tag);
  endtask

  // Alert-response read against another responder with address other
  // (7'h7F stands for no competing device)
  task automatic araRead(input logic [6:0] other, input bit pending,
                         input logic [NA-1:0] al, input logic [NA-1:0] alEnd,
                         input bit expEndA, input string tag);
    logic [7:0] mine, theirs;
    bit inGame;
    mine = {MY_ADDR, 1'b1};
    theirs = {other, 1'b1};
    inGame = pending;
    // R6 first frame bit presented after start; R7 nothing if not pending
    step(al, 1'b0, 1'b1, 1'b0, 1'b1, !pending, pending & ~mine[7],
         pending ? "R6 start" : "R7 start");
    for (int i = 0; i < 8; i++) begin
      logic bus;
      bit eD, eA;
      string t;
      bus = theirs[7-i] & (inGame ? mine[7-i] : 1'b1);
      if (inGame && mine[7-i] && !bus) inGame = 1'b0;
      eA = !pending;
      if (i == 7) begin
        eD = 1'b0;
        eA = inGame ? expEndA : !pending;
        t = tag;
      end else begin
        eD = inGame & ~mine[6-i];
        t = inGame ? "R6 frame bit" : (pending ? "R8 released" : "R7 silent");
      end
      step((i == 7) ? alEnd : al, 1'b0, 1'b0, 1'b1, bus, eA, eD, t);
      // idle cycle between bits: nothing changes
      step((i == 7) ? alEnd : al, 1'b0, 1'b0, 1'b0, 1'b1, eA, eD, "R5 idle between bits");
    end
  endtask

  initial begin
    // R1 reset state; alarm bit 0 already high during reset
    alarmIn = 5'b00001;
    step(5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 in reset");
    step(5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    expA.push_back(1'b1); expD.push_back(1'b0); tagQ.push_back("R3 first clock after reset");
    step(5'b00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 held level no set");
    // R2 rising alarm bit 1
    step(5'b00011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 rise sets latch");
    step(5'b00011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 latch held");
    // R8 lose to lower address 7'h15
    araRead(7'h15, 1'b1, 5'b00011, 5'b00011, 1'b0, "R8 lost keeps alert");
    step(5'b00011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 alert still low");
    // R9 win with no competitor
    araRead(7'h7F, 1'b1, 5'b00011, 5'b00011, 1'b1, "R9 win clears latch");
    step(5'b00011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 held alarm no retrigger");
    // R4 mask discards a rise
    step(5'b00111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 masked rise");
    step(5'b00111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 unmask no late set");
    // R7 read with nothing pending
    araRead(7'h7F, 1'b0, 5'b00111, 5'b00111, 1'b1, "R7 no response");
    // R2 again, then R4 mask does not clear an existing latch
    step(5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 alarms low");
    step(5'b10000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 rise bit 4");
    step(5'b10000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 mask keeps latch");
    // R10 win coincides with a fresh rise on bit 0
    araRead(7'h7F, 1'b1, 5'b10000, 5'b10001, 1'b0, "R10 set wins over clear");
    // R9 win against a higher address 7'h3A
    araRead(7'h3A, 1'b1, 5'b10001, 5'b10001, 1'b1, "R9 win over higher address");
    step(5'b10001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 stays clear");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule